// File: doc/BRIEF.md
# Inter-Channel Edge Skew Detector

The block measures how far apart in time the rising edges of three sampled signal channels arrive. Each signed sample stream is turned into a binary signal by comparing it against a common slicing threshold. The threshold comes from a small two's-complement code. Three detectors are arranged in a ring: red against green, green against blue, and blue against red. Each detector measures how many samples the leading edge arrives ahead of the lagging one. Once both signals are high, it replays that count as a pulse on its up output when the first signal of the pair led, or on its down output when the second one led. The pulse width in clock cycles therefore equals the skew in samples. Downstream logic can average or count the pulses to steer per-channel delay settings.

A test mode reroutes the red and blue detectors. Each of them then compares its channel's undelayed source stream with the same channel's delayed stream, which measures the delay that was inserted. The green detector is held quiet in test mode. The threshold value is always available on its own output. Processing runs at one sample per clock.

Top module: `skew_edge_detect`

## Requirements
- R1: `thr_o` equals the signed value of `thr_code_i` (4-bit two's complement) times STEP_MV (default 50): code 4'b1000 gives -400, 4'b0000 gives 0 and 4'b0111 gives +350.
- R2: A sample counts as high when it is greater than or equal to `thr_o`; a sample one below the threshold counts as low.
- R3: Pair index 0 uses red (first) against green (second), index 1 uses green against blue, and index 2 uses blue against red, where red, green and blue are `dly_r_i`, `dly_g_i` and `dly_b_i` in normal mode.
- R4: If the first signal of a pair rises k samples before the second (1 <= k <= MAX_SKEW) and is still high when the second rises, `up_o[i]` is high for exactly k consecutive cycles. The mirror case produces the same on `dn_o[i]`.
- R5: Take a lagging sample driven before clock edge n. The pulse it completes is high from just after edge n+1.
- R6: No pulse is produced if the leading signal falls before or at the cycle in which the lagging one rises, or if both rise in the same sample.
- R7: A skew larger than MAX_SKEW samples (default 15) produces no pulse.
- R8: `up_o[i]` and `dn_o[i]` are never high in the same cycle.
- R9: After an edge pair has been measured or rejected, a detector ignores further edges until both of its signals have been low in the same sample.
- R10: With `test_mode_i` high, pair 0 compares `src_r_i` (first) with `dly_r_i` (second), pair 2 compares `src_b_i` with `dly_b_i`, and pair 1 drives both of its outputs low.
- R11: During and right after reset all up and down outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dly_r_i | input | SAMPLE_W | Red delayed sample stream, signed |
| dly_g_i | input | SAMPLE_W | Green delayed sample stream, signed |
| dly_b_i | input | SAMPLE_W | Blue delayed sample stream, signed |
| src_r_i | input | SAMPLE_W | Red undelayed sample stream, signed (test mode) |
| src_b_i | input | SAMPLE_W | Blue undelayed sample stream, signed (test mode) |
| thr_code_i | input | CODE_W | Slicing threshold code, two's complement |
| test_mode_i | input | 1 | Selects test-mode pairing |
| up_o | output | 3 | Per-pair pulse: first signal led |
| dn_o | output | 3 | Per-pair pulse: second signal led |
| thr_o | output | SAMPLE_W | Slicing threshold value, signed |

## Verification
A detector stuck in the wrong state shows up at the ports within one edge episode in one of two ways. A stuck measure or emit state gives a pulse whose cycle count does not match the programmed skew. A missed re-arm swallows the next pulse completely. Both show up as soon as the bench compares per-pair up and down cycle counts after each episode. A wrong pair routing or slicing comparison shows up as pulse counts on the wrong pair or with the wrong sign, or as a total absence of pulses in the exact-threshold episode. A latency error moves the first pulse cycle away from the cycle the bench predicts.

// File: rtl/skew_pkg.sv
package skew_pkg;

  localparam int NUM_PAIRS = 3;
  localparam int NUM_STREAMS = 5;

  typedef enum logic [1:0] {
    ST_WAIT_LOW = 2'd0,
    ST_ARMED    = 2'd1,
    ST_MEAS     = 2'd2,
    ST_EMIT     = 2'd3
  } det_state_e;

endpackage

// File: rtl/skew_thresh.sv
module skew_thresh #(
  parameter int SAMPLE_W = 12,
  parameter int CODE_W   = 4,
  parameter int STEP_MV  = 50
) (
  input  logic [CODE_W-1:0]          code_i,
  output logic signed [SAMPLE_W-1:0] thr_o
);

  logic signed [CODE_W-1:0] code_s;
  logic signed [31:0]       prod;

  assign code_s = code_i;
  assign prod   = 32'(code_s) * 32'(STEP_MV);
  assign thr_o  = prod[SAMPLE_W-1:0];

endmodule

// File: rtl/skew_slicer.sv
module skew_slicer #(
  parameter int SAMPLE_W = 12,
  parameter int NUM_CH   = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CH*SAMPLE_W-1:0]   samp_i,
  input  logic signed [SAMPLE_W-1:0]   thr_i,
  output logic [NUM_CH-1:0]            bit_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic signed [SAMPLE_W-1:0] s;
    logic                       q;
    assign s = samp_i[c*SAMPLE_W +: SAMPLE_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= (s >= thr_i);
    end
    assign bit_o[c] = q;
  end

endmodule

// File: rtl/skew_pair_det.sv
module skew_pair_det
  import skew_pkg::*;
#(
  parameter int MAX_SKEW = 15,
  localparam int CNT_W   = $clog2(MAX_SKEW + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic a_i,
  input  logic b_i,
  output logic up_o,
  output logic dn_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_SKEW);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  det_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;   // 0: a leads, 1: b leads
  logic             lead, lag;

  assign lead = dir_q ? b_i : a_i;
  assign lag  = dir_q ? a_i : b_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    dir_d = dir_q;
    unique case (st_q)
      ST_WAIT_LOW: begin
        if (!a_i && !b_i) st_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (a_i && b_i) begin
          st_d = ST_WAIT_LOW;       // zero skew
        end else if (a_i || b_i) begin
          st_d  = ST_MEAS;
          dir_d = b_i;
          cnt_d = CNT_ONE;
        end
      end
      ST_MEAS: begin
        if (!lead) begin
          st_d  = ST_WAIT_LOW;      // no overlap
          cnt_d = '0;
        end else if (lag) begin
          st_d = ST_EMIT;
        end else if (cnt_q == CNT_MAX) begin
          st_d  = ST_WAIT_LOW;      // out of range
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      ST_EMIT: begin
        if (cnt_q == CNT_ONE) begin
          st_d  = ST_WAIT_LOW;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      default: st_d = ST_WAIT_LOW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_WAIT_LOW;
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (clr_i) begin
      st_q  <= ST_WAIT_LOW;
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign up_o = (st_q == ST_EMIT) && !dir_q;
  assign dn_o = (st_q == ST_EMIT) &&  dir_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX) else $error("count out of range"); // R7

  AST_ARM_BOTH_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED) && ($past(st_q) != ST_ARMED) |-> $past(!a_i && !b_i))
    else $error("armed without both low"); // R9

  AST_PULSE_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_o || dn_o) |-> $past(a_i && b_i))
    else $error("pulse without overlap"); // R6

  AST_EMIT_DIR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EMIT) && ($past(st_q) == ST_EMIT) |-> $stable(dir_q))
    else $error("pulse sign changed"); // R4

endmodule

// File: rtl/skew_edge_detect.sv
module skew_edge_detect
  import skew_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int CODE_W   = 4,
  parameter int STEP_MV  = 50,
  parameter int MAX_SKEW = 15
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] dly_r_i,
  input  logic signed [SAMPLE_W-1:0] dly_g_i,
  input  logic signed [SAMPLE_W-1:0] dly_b_i,
  input  logic signed [SAMPLE_W-1:0] src_r_i,
  input  logic signed [SAMPLE_W-1:0] src_b_i,
  input  logic [CODE_W-1:0]          thr_code_i,
  input  logic                       test_mode_i,
  output logic [NUM_PAIRS-1:0]       up_o,
  output logic [NUM_PAIRS-1:0]       dn_o,
  output logic signed [SAMPLE_W-1:0] thr_o
);

  logic signed [SAMPLE_W-1:0]       thr;
  logic [NUM_STREAMS*SAMPLE_W-1:0]  samp;
  logic [NUM_STREAMS-1:0]           bits;
  logic [NUM_PAIRS-1:0]             a_sel, b_sel, clr;
  logic                             test_q, mode_chg;

  skew_thresh #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .STEP_MV(STEP_MV)) u_thresh (
    .code_i (thr_code_i),
    .thr_o  (thr)
  );

  assign thr_o = thr;
  // stream order: 0 dly_r, 1 dly_g, 2 dly_b, 3 src_r, 4 src_b
  assign samp = {src_b_i, src_r_i, dly_b_i, dly_g_i, dly_r_i};

  skew_slicer #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_STREAMS)) u_slicer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .samp_i (samp),
    .thr_i  (thr),
    .bit_o  (bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) test_q <= 1'b0;
    else         test_q <= test_mode_i;
  end
  assign mode_chg = test_mode_i ^ test_q;

  always_comb begin
    if (test_mode_i) begin
      a_sel = {bits[4], bits[1], bits[3]};
      b_sel = {bits[2], bits[2], bits[0]};
    end else begin
      a_sel = {bits[2], bits[1], bits[0]};
      b_sel = {bits[0], bits[2], bits[1]};
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    if (p == 1) begin : g_grn
      assign clr[p] = mode_chg | test_mode_i;
    end else begin : g_rb
      assign clr[p] = mode_chg;
    end

    skew_pair_det #(.MAX_SKEW(MAX_SKEW)) u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr[p]),
      .a_i    (a_sel[p]),
      .b_i    (b_sel[p]),
      .up_o   (up_o[p]),
      .dn_o   (dn_o[p])
    );

    AST_UP_DN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(up_o[p] && dn_o[p])) else $error("up and down together"); // R8
  end

  AST_GRN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_i && $past(test_mode_i) |-> !up_o[1] && !dn_o[1])
    else $error("green pair active in test mode"); // R10

endmodule

// File: tb/skew_edge_detect_bench.sv
`timescale 1ns/1ps
module skew_edge_detect_bench;

  localparam int SW  = 12;
  localparam int MAX = 15;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic signed [SW-1:0] smp [5];
  logic [3:0] code = 4'd0;
  logic test_mode = 1'b0;
  logic [2:0] up_o, dn_o;
  logic signed [SW-1:0] thr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int ep_rise [5];
  int ep_hi   [5];
  int ep_rise2[5];
  int ep_hi2  [5];
  int up_cnt [3];
  int dn_cnt [3];
  int first_up[3];
  int excl_bad;

  always #2 clk = ~clk;

  skew_edge_detect u_skew_edge_detect (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .dly_r_i     (smp[0]),
    .dly_g_i     (smp[1]),
    .dly_b_i     (smp[2]),
    .src_r_i     (smp[3]),
    .src_b_i     (smp[4]),
    .thr_code_i  (code),
    .test_mode_i (test_mode),
    .up_o        (up_o),
    .dn_o        (dn_o),
    .thr_o       (thr_o)
  );

  function automatic int exp_thr(input logic [3:0] c);
    return (c[3] ? int'(c) - 16 : int'(c)) * 50;
  endfunction

  // + : up length, - : down length, 0 : no pulse
  function automatic int exp_len(input int ta, input int ha, input int tb, input int hb);
    int d;
    d = tb - ta;
    if (d > 0) return (ha > d && d <= MAX) ? d : 0;
    if (d < 0) return (hb > -d && -d <= MAX) ? d : 0;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_ep();
    for (int c = 0; c < 5; c++) begin
      ep_rise[c] = 1000; ep_hi[c] = 0; ep_rise2[c] = 1000; ep_hi2[c] = 0;
    end
  endtask

  task automatic run_ep(input logic [3:0] new_code, input bit exact);
    int end_t, thr, m;
    bit hi;
    m = 0;
    for (int c = 0; c < 5; c++) begin
      if (ep_hi[c] > 0 && ep_rise[c] + ep_hi[c] > m) m = ep_rise[c] + ep_hi[c];
      if (ep_hi2[c] > 0 && ep_rise2[c] + ep_hi2[c] > m) m = ep_rise2[c] + ep_hi2[c];
    end
    end_t = m + 2 * MAX + 8;
    thr = exp_thr(new_code);
    for (int p = 0; p < 3; p++) begin up_cnt[p] = 0; dn_cnt[p] = 0; first_up[p] = -1; end
    excl_bad = 0;
    for (int t = 0; t < end_t; t++) begin
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        if (up_o[p]) begin up_cnt[p]++; if (first_up[p] < 0) first_up[p] = t; end
        if (dn_o[p]) dn_cnt[p]++;
        if (up_o[p] && dn_o[p]) excl_bad++;
      end
      if (t == 0) code = new_code;
      for (int c = 0; c < 5; c++) begin
        hi = (t >= ep_rise[c] && t < ep_rise[c] + ep_hi[c]) ||
             (t >= ep_rise2[c] && t < ep_rise2[c] + ep_hi2[c]);
        if (hi) smp[c] = SW'(thr + (exact ? 0 : int'($urandom_range(0, 300))));
        else    smp[c] = SW'(thr - 1 - (exact ? 0 : int'($urandom_range(0, 300))));
      end
    end
    chk(excl_bad == 0, "R8", "up/down overlap cycles", excl_bad, 0);
  endtask

  task automatic check_pairs(input string req);
    int e [3];
    if (!test_mode) begin
      e[0] = exp_len(ep_rise[0], ep_hi[0], ep_rise[1], ep_hi[1]);
      e[1] = exp_len(ep_rise[1], ep_hi[1], ep_rise[2], ep_hi[2]);
      e[2] = exp_len(ep_rise[2], ep_hi[2], ep_rise[0], ep_hi[0]);
    end else begin
      e[0] = exp_len(ep_rise[3], ep_hi[3], ep_rise[0], ep_hi[0]);
      e[1] = 0;
      e[2] = exp_len(ep_rise[4], ep_hi[4], ep_rise[2], ep_hi[2]);
    end
    for (int p = 0; p < 3; p++) begin
      chk(up_cnt[p] == (e[p] > 0 ? e[p] : 0), req, $sformatf("pair %0d up cycles", p),
          up_cnt[p], (e[p] > 0 ? e[p] : 0));
      chk(dn_cnt[p] == (e[p] < 0 ? -e[p] : 0), req, $sformatf("pair %0d down cycles", p),
          dn_cnt[p], (e[p] < 0 ? -e[p] : 0));
    end
  endtask

  task automatic rand_ep(input bit tm);
    int base, d;
    clear_ep();
    for (int c = 0; c < 5; c++) begin
      ep_rise[c] = 3 + int'($urandom_range(0, 24));
      ep_hi[c]   = 1 + int'($urandom_range(0, 29));
    end
    if (tm) begin
      base = 3 + int'($urandom_range(0, 8));
      d = int'($urandom_range(0, 20));
      ep_rise[3] = base; ep_rise[0] = base + d; ep_hi[0] = ep_hi[3];
      base = 3 + int'($urandom_range(0, 8));
      d = int'($urandom_range(0, 20));
      ep_rise[4] = base; ep_rise[2] = base + d; ep_hi[2] = ep_hi[4];
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < 5; c++) smp[c] = -SW'(1);
    repeat (3) @(negedge clk);
    chk(up_o == 3'b000 && dn_o == 3'b000, "R11", "outputs in reset", {up_o, dn_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(up_o == 3'b000 && dn_o == 3'b000, "R11", "outputs after reset", {up_o, dn_o}, 0);

    // R1: every code
    for (int k = 0; k < 16; k++) begin
      code = 4'(k);
      #1;
      chk(int'(thr_o) == exp_thr(4'(k)), "R1", $sformatf("threshold code %0d", k),
          int'(thr_o), exp_thr(4'(k)));
    end
    code = 4'd0;
    @(negedge clk);
    for (int c = 0; c < 5; c++) smp[c] = -SW'(1);
    repeat (4) @(negedge clk);

    // R4/R5: red leads green by 3, first pulse cycle
    clear_ep();
    ep_rise[0] = 3; ep_hi[0] = 10; ep_rise[1] = 6; ep_hi[1] = 10; ep_rise[2] = 40; ep_hi[2] = 2;
    run_ep(4'd0, 1'b0);
    check_pairs("R4");
    chk(first_up[0] == 8, "R5", "first up cycle", first_up[0], 8);

    // R3: green leads red -> pair0 down, blue leads green -> pair1 down, blue vs red up
    clear_ep();
    ep_rise[1] = 4; ep_hi[1] = 20; ep_rise[0] = 9; ep_hi[0] = 20; ep_rise[2] = 3; ep_hi[2] = 20;
    run_ep(4'd2, 1'b0);
    check_pairs("R3");

    // R2: samples exactly at the threshold and one below
    clear_ep();
    ep_rise[0] = 3; ep_hi[0] = 12; ep_rise[1] = 7; ep_hi[1] = 12; ep_rise[2] = 5; ep_hi[2] = 12;
    run_ep(4'b0111, 1'b1);
    check_pairs("R2");
    chk(up_cnt[0] == 4, "R2", "boundary slicing pulse", up_cnt[0], 4);

    // R7: skew at and beyond the limit
    clear_ep();
    ep_rise[0] = 3; ep_hi[0] = 30; ep_rise[1] = 3 + MAX; ep_hi[1] = 5; ep_rise[2] = 3; ep_hi[2] = 30;
    run_ep(4'b1000, 1'b0);
    check_pairs("R7");
    clear_ep();
    ep_rise[0] = 3; ep_hi[0] = 30; ep_rise[1] = 4 + MAX; ep_hi[1] = 5; ep_rise[2] = 3; ep_hi[2] = 30;
    run_ep(4'b1000, 1'b0);
    check_pairs("R7");
    chk(up_cnt[0] == 0, "R7", "skew over limit", up_cnt[0], 0);

    // R6: no overlap, and simultaneous rise
    clear_ep();
    ep_rise[0] = 3; ep_hi[0] = 4; ep_rise[1] = 7; ep_hi[1] = 6; ep_rise[2] = 3; ep_hi[2] = 10;
    run_ep(4'd1, 1'b0);
    check_pairs("R6");
    chk(up_cnt[0] == 0, "R6", "leader fell at lagger rise", up_cnt[0], 0);

    // R9: red rises again while green is still high -> ignored
    clear_ep();
    ep_rise[0] = 2; ep_hi[0] = 4; ep_rise2[0] = 8; ep_hi2[0] = 5;
    ep_rise[1] = 4; ep_hi[1] = 12;
    run_ep(4'd0, 1'b0);
    chk(up_cnt[0] == 2 && dn_cnt[0] == 0, "R9", "pair0 up cycles, second edge ignored", up_cnt[0], 2);
    chk(up_cnt[1] == 0 && dn_cnt[1] == 0, "R9", "pair1 cycles", up_cnt[1] + dn_cnt[1], 0);
    chk(up_cnt[2] == 0 && dn_cnt[2] == 0, "R9", "pair2 cycles", up_cnt[2] + dn_cnt[2], 0);

    // random normal mode
    for (int n = 0; n < 40; n++) begin
      rand_ep(1'b0);
      run_ep(4'($urandom_range(0, 15)), 1'b0);
      check_pairs("R4");
    end

    // test mode: directed then random
    test_mode = 1'b1;
    clear_ep();
    ep_rise[3] = 4; ep_hi[3] = 12; ep_rise[0] = 9; ep_hi[0] = 12;
    ep_rise[4] = 3; ep_hi[4] = 12; ep_rise[2] = 5; ep_hi[2] = 12;
    ep_rise[1] = 3; ep_hi[1] = 12;
    run_ep(4'd0, 1'b0);
    check_pairs("R10");
    chk(up_cnt[0] == 5, "R10", "red source vs delayed", up_cnt[0], 5);
    for (int n = 0; n < 20; n++) begin
      rand_ep(1'b1);
      run_ep(4'($urandom_range(0, 15)), 1'b0);
      check_pairs("R10");
    end
    test_mode = 1'b0;
    for (int n = 0; n < 5; n++) begin
      rand_ep(1'b0);
      run_ep(4'($urandom_range(0, 15)), 1'b0);
      check_pairs("R3");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule